// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner out of N requestors each cycle and keeps them fair by remembering, for every pair of requestors, which of the two was served more recently. The one served longer ago wins the next conflict between them. It is meant for small N, typically 4 to 8. Typical uses inside a router are choosing among virtual channels or among inputs that compete for a switch port.

Requests are plain level signals, not a valid/ready stream. The grant is combinational from the request vector and the stored precedence. The caller asserts the update enable in any cycle whose grant is actually consumed. A grant is committed to the precedence state on the rising clock edge only when the enable is high. If the consumer stalls, it holds the enable low and the same winner is offered again.

Precedence is kept as one flip-flop per unordered pair (i<j): N·(N−1)/2 bits. A set bit means the lower index i beats j. The reverse relation is the complement of that bit and is never stored.

Top module: `lrs_matrix_arbiter`

## Requirements
- R1: After reset every pair bit is set, so among any set of requestors the lowest index is granted.
- R2: The grant vector has at most one bit set in every cycle.
- R3: A grant bit is only ever set for an input whose request bit is set; an all-zero request vector gives an all-zero grant.
- R4: Whenever at least one request bit is set, exactly one grant bit is set in the same cycle.
- R5: Input i is granted exactly when it requests and no other requesting input currently has precedence over it.
- R6: On a clock edge with the update enable high and input k granted, k loses precedence to every other input: bits (k,j) for j>k clear and bits (i,k) for i<k set.
- R7: On a clock edge with the update enable low, the precedence state is unchanged, so the same request vector yields the same grant in the next cycle.
- R8: On a clock edge with the update enable high but no request, the precedence state is unchanged.
- R9: An input that requests continuously is granted before more than N−1 committed grants have gone to other inputs.
- R10: The grant responds to a new request vector in the same cycle, with no register between request and grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; restores the index-ordered precedence |
| req_i | input | N | Request vector, one bit per requestor |
| upd_en_i | input | 1 | Commit the current grant into the precedence state at the next edge |
| gnt_o | output | N | One-hot (or zero) grant vector |

## Verification
The hardest condition to reach from the ports is the worst-case wait. One input requests without pause while every other input is granted exactly once ahead of it. That requires a precedence order in which the steady requestor sits at the bottom, followed by bursts that serve the others one at a time. A pseudo-random request pattern keeps input 3 requesting and toggles the others and the update enable. This drives the state through many orderings, including repeated full-wait chains, and a per-input wait count is checked against N−1 on every committed grant. A directed vector walk steers the state into known orders first. It then checks stalled commits and empty-request commits, which must both leave the order untouched.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;

  // Flat index of pair (i,j), i<j, inside the triangular store for n inputs.
  function automatic int pair_idx(input int i, input int j, input int n);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  function automatic int pair_count(input int n);
    return (n * (n - 1)) / 2;
  endfunction

endpackage

// File: rtl/lrs_prec_store.sv
module lrs_prec_store
  import lrs_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit_i,
  input  logic [N-1:0]   win_i,
  output logic [N*N-1:0] beats_o   // bit a*N+b : a has precedence over b
);

  localparam int NP = pair_count(N);

  logic [NP-1:0] pair_q;
  logic          do_upd;

  assign do_upd = commit_i & (|win_i);

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i < j) begin : g_upper
        localparam int IDX = pair_idx(i, j, N);
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            bit_q <= 1'b1;
          end else if (do_upd) begin
            if (win_i[i])      bit_q <= 1'b0;
            else if (win_i[j]) bit_q <= 1'b1;
          end
        end
        assign pair_q[IDX]     = bit_q;
        assign beats_o[i*N+j]  = bit_q;

        // R6: a served lower index falls below the higher one
        assert_row_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (commit_i && win_i[i]) |=> !bit_q);
        // R6: a served higher index falls below the lower one
        assert_col_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (commit_i && win_i[j]) |=> bit_q);
      end else if (i > j) begin : g_lower
        localparam int IDX = pair_idx(j, i, N);
        assign beats_o[i*N+j] = ~pair_q[IDX];
      end else begin : g_diag
        assign beats_o[i*N+j] = 1'b0;
      end
    end
  end

  // R7, R8: no committed grant leaves the order alone
  assert_hold_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i || win_i == '0) |=> $stable(pair_q));

endmodule

// File: rtl/lrs_grant_pick.sv
module lrs_grant_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]   req_i,
  input  logic [N*N-1:0] beats_i,
  output logic [N-1:0]   gnt_o
);

  for (genvar i = 0; i < N; i++) begin : g_cand
    logic [N-1:0] over_me;   // requestors that beat candidate i
    for (genvar j = 0; j < N; j++) begin : g_rival
      assign over_me[j] = req_i[j] & beats_i[j*N+i];
    end
    assign gnt_o[i] = req_i[i] & ~(|over_me);
  end

endmodule

// File: rtl/lrs_matrix_arbiter.sv
module lrs_matrix_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         upd_en_i,
  output logic [N-1:0] gnt_o
);

  localparam int WCW = $clog2(N) + 1;

  logic [N*N-1:0] beats;

  lrs_prec_store #(.N(N)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (upd_en_i),
    .win_i    (gnt_o),
    .beats_o  (beats)
  );

  lrs_grant_pick #(.N(N)) u_pick (
    .req_i   (req_i),
    .beats_i (beats),
    .gnt_o   (gnt_o)
  );

  // R2
  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  // R3
  assert_gnt_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);
  // R4
  assert_req_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> ($countones(gnt_o) == 1));

  // R9: count committed grants to others while an input keeps requesting
  for (genvar k = 0; k < N; k++) begin : g_wait
    logic [WCW-1:0] wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         wait_q <= '0;
      else if (!req_i[k] || gnt_o[k])     wait_q <= '0;
      else if (upd_en_i && (|gnt_o))      wait_q <= wait_q + 1'b1;
    end
    assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= WCW'(N - 1));
  end

endmodule

// File: tb/lrs_matrix_arbiter_tb.sv
module lrs_matrix_arbiter_tb_top;

  localparam int CLK_PER = 10;
  localparam int N = 4;
  localparam int NV = 13;
  // {req[3:0], upd, expected grant[3:0]}
  localparam logic [8:0] VEC [NV] = '{
    {4'b1111, 1'b1, 4'b0001},  // R1 fresh order 0,1,2,3
    {4'b1111, 1'b1, 4'b0010},  // R6 0 moved to bottom
    {4'b0011, 1'b1, 4'b0001},  // R5 0 still above 1? no: 1 served -> 0 wins
    {4'b0011, 1'b0, 4'b0010},  // R6 0 served, 1 now wins
    {4'b0011, 1'b0, 4'b0010},  // R7 stalled commit, same winner
    {4'b0000, 1'b1, 4'b0000},  // R3 R8 empty request
    {4'b1000, 1'b1, 4'b1000},  // R4 lone requestor
    {4'b1111, 1'b1, 4'b0100},  // R5 order 2,1,0,3
    {4'b1100, 1'b1, 4'b1000},  // R6 2 at bottom, 3 wins
    {4'b1101, 1'b1, 4'b0001},  // R5 order 1,0,2,3
    {4'b1111, 1'b1, 4'b0010},  // R5 order 1,2,3,0
    {4'b0101, 1'b1, 4'b0100},  // R5 order 2,3,0,1
    {4'b0110, 1'b1, 4'b0010}   // R5 order 3,0,1,2
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         upd = 1'b0;
  logic [N-1:0] gnt;
  int           n_chk = 0;
  int           n_err = 0;
  logic         done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  lrs_matrix_arbiter #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .upd_en_i(upd), .gnt_o(gnt)
  );

  task automatic chk(input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic chk_bit(input string rq, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    int wcnt [N];
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk("R3 reset idle", gnt, '0);
    rst_n = 1'b1;

    // vector walk; grant sampled 1 after negedge, commit at next posedge (R10)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req = VEC[v][8:5];
      upd = VEC[v][4];
      #1 chk($sformatf("R5 vector %0d", v), gnt, VEC[v][3:0]);
    end

    // R1: reset restores index order
    @(negedge clk); rst_n = 1'b0; req = '0; upd = 1'b0;
    @(negedge clk); rst_n = 1'b1; req = 4'b1111;
    #1 chk("R1 reset order all", gnt, 4'b0001);
    @(negedge clk); req = 4'b1110;
    #1 chk("R1 reset order upper", gnt, 4'b0010);
    @(negedge clk); req = 4'b1100;
    #1 chk("R1 reset order top", gnt, 4'b0100);

    // R4: each lone requestor is served
    for (int i = 0; i < N; i++) begin
      @(negedge clk); req = 4'(1 << i); upd = 1'b1;
      #1 chk($sformatf("R4 lone %0d", i), gnt, 4'(1 << i));
    end
    // after serving 0,1,2,3 in order the order is back to 0,1,2,3 (R6)
    @(negedge clk); req = 4'b1111; upd = 1'b0;
    #1 chk("R6 cyclic return", gnt, 4'b0001);

    // R9 + R2/R3 under pseudo-random load; input 3 always requests
    lfsr = 8'hA5;
    for (int i = 0; i < N; i++) wcnt[i] = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req = lfsr[3:0] | 4'b1000;
      upd = lfsr[7] | lfsr[6];
      #1;
      chk_bit("R2 one-hot", $countones(gnt) == 1, $countones(gnt), 1);
      chk("R3 subset", gnt & ~req, '0);
      for (int i = 0; i < N; i++) begin
        if (!req[i] || gnt[i]) wcnt[i] = 0;
        else if (upd && gnt != '0) wcnt[i] = wcnt[i] + 1;
        if (wcnt[i] > N - 1)
          chk_bit($sformatf("R9 wait input %0d", i), 1'b0, wcnt[i], N - 1);
      end
      if (wcnt[3] != 0 || gnt[3])
        chk_bit("R9 wait input 3", wcnt[3] <= N - 1, wcnt[3], N - 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule